// File: doc/BRIEF.md
# Dual-Tone Keypad Signalling Generator

This block turns a keypad digit into the two audio-band square waves used for touch-tone signalling. Both tones are derived from a 3.579545 MHz clock by integer dividers. The divider ratios are computed at elaboration as the nearest integer to the clock rate divided by each target tone. This gives row tones of about 699, 766, 848 and 948 Hz and column tones of about 1216, 1332 and 1472 Hz.

A digit arrives on a valid/ready handshake. Once a digit is accepted, both tones play for a fixed burst length. A fixed silent gap follows before the next digit can be taken. When the keypad scanner sees more than one key pressed at once, it raises a single-tone flag with the digit, and only one of the two tone groups sounds. Each accepted digit also starts a short 1.2 kHz key-click burst on a separate output. A tone-mode enable gates the whole tone path. Summing the tones and shaping them into analog form are left to logic outside this block.

Top module: `dtmf_tone_gen`

## Requirements
- R1: Digit codes map to four rows as follows: 1,2,3 → row 0; 4,5,6 → row 1; 7,8,9 → row 2; `*`,0,`#` → row 3. Digits 0–9 use codes 0–9, `*` uses code 10 and `#` uses code 11. During a burst, `row_sq` has a period of exactly round(CLK_HZ / row frequency) cycles, which is 5121, 4673, 4221 or 3776 for the default frequencies.
- R2: Digit codes map to three columns as follows: 1,4,7,`*` → column 0; 2,5,8,0 → column 1; 3,6,9,`#` → column 2. During a burst, `col_sq` has a period of round(CLK_HZ / column frequency) cycles, which is 2944, 2687 or 2432 for the default frequencies.
- R3: `tone_on` rises in the cycle after a digit is accepted and stays high for exactly TONE_CYC cycles. Both square waves start high in that first cycle.
- R4: After `tone_on` falls, `dig_ready` stays low for exactly GAP_CYC further cycles, then returns high.
- R5: If `single_en` is high when a digit is accepted, only one tone group sounds for that burst. With `single_col` = 0 the row tone sounds and `col_sq` stays low. With `single_col` = 1 the column tone sounds and `row_sq` stays low.
- R6: Each accepted valid digit starts a key-click burst on `click_out`. The burst is a square wave with a period of round(CLK_HZ / 1200) cycles, which is 2983 by default, lasting CLICK_CYC cycles. Outside a burst `click_out` is low.
- R7: While `tone_mode` is low, `dig_ready`, `row_sq`, `col_sq` and `tone_on` are low. Lowering `tone_mode` during a burst ends the burst at the next clock edge. A digit offered while `tone_mode` is low is not kept for later.
- R8: Codes 12–15 are consumed by the handshake but produce no tone and no click, and `dig_ready` stays high.
- R9: After reset with `tone_mode` high, `dig_ready` is high and `row_sq`, `col_sq`, `tone_on` and `click_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tone reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tone_mode | input | 1 | Enables the tone path |
| dig_valid | input | 1 | Digit offered |
| dig_ready | output | 1 | Block can accept a digit |
| dig_code | input | 4 | Digit code (0–9, 10 = `*`, 11 = `#`) |
| single_en | input | 1 | Sound only one tone group for this digit |
| single_col | input | 1 | Selects which group sounds when `single_en` is high (1 = column) |
| row_sq | output | 1 | Row-group square wave |
| col_sq | output | 1 | Column-group square wave |
| tone_on | output | 1 | Tone burst in progress |
| click_out | output | 1 | Key-click square wave |

## Verification
The bench measures the interval between rising edges of each square wave for every row and every column. A wrong divider ratio, or a digit routed to the wrong row or column, shows up directly as a wrong period. It counts the burst length and the gap cycle by cycle. An off-by-one in the sequencer timer would lengthen or shorten either window by a cycle, or reopen `dig_ready` too early. It plays digits with both settings of the single-tone flag and checks that the muted group stays low. It offers out-of-range codes and checks that no tone or click follows. It also drops tone mode in the middle of a burst and checks that the burst stops and that a digit offered while the mode is off is not played once the mode returns.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_TONE = 2'd1,
      ST_GAP  = 2'd2
   } dtmf_state_e;

   // nearest-integer divider ratio for a target frequency
   function automatic int unsigned near_div(input int unsigned clk_hz, input int unsigned f_hz);
      return (clk_hz + f_hz / 2) / f_hz;
   endfunction

   function automatic logic code_ok(input logic [3:0] code);
      return code <= 4'd11;
   endfunction

   function automatic logic [1:0] row_of(input logic [3:0] code);
      logic [1:0] r;
      case (code)
         4'd1, 4'd2, 4'd3:   r = 2'd0;
         4'd4, 4'd5, 4'd6:   r = 2'd1;
         4'd7, 4'd8, 4'd9:   r = 2'd2;
         default:            r = 2'd3;
      endcase
      return r;
   endfunction

   function automatic logic [1:0] col_of(input logic [3:0] code);
      logic [1:0] c;
      case (code)
         4'd1, 4'd4, 4'd7, 4'd10: c = 2'd0;
         4'd2, 4'd5, 4'd8, 4'd0:  c = 2'd1;
         default:                 c = 2'd2;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/dtmf_sqdiv.sv
module dtmf_sqdiv #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] div,
   output logic         sq
);
   logic [W-1:0] cnt;
   logic [W-1:0] half;

   assign half = div >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (!en)             cnt <= '0;
      else if (cnt == div - W'(1)) cnt <= '0;
      else                      cnt <= cnt + W'(1);
   end

   assign sq = en && (cnt < half);

   // R3: each burst starts with the wave high
   a_r3_phase_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> sq);

   // R1: ratio held for the whole burst
   a_r1_div_held: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en)) |-> $stable(div));
endmodule

// File: rtl/dtmf_seq.sv
module dtmf_seq
   import dtmf_pkg::*;
#(
   parameter int TONE_CYC = 332898,
   parameter int GAP_CYC  = 332898,
   parameter int CNT_W    = 19
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tone_mode,
   input  logic start,
   output logic tone_on,
   output logic idle
);
   dtmf_state_e  st;
   logic [CNT_W-1:0] tcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         tcnt <= '0;
      end else if (!tone_mode) begin
         st   <= ST_IDLE;
         tcnt <= '0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               st   <= ST_TONE;
               tcnt <= '0;
            end
            ST_TONE: if (tcnt == CNT_W'(TONE_CYC - 1)) begin
               st   <= ST_GAP;
               tcnt <= '0;
            end else tcnt <= tcnt + CNT_W'(1);
            ST_GAP: if (tcnt == CNT_W'(GAP_CYC - 1)) begin
               st   <= ST_IDLE;
               tcnt <= '0;
            end else tcnt <= tcnt + CNT_W'(1);
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign tone_on = (st == ST_TONE);
   assign idle    = (st == ST_IDLE);

   // R3: burst follows acceptance
   a_r3_burst_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (start && tone_mode && idle) |=> tone_on);

   // R4: a normal end of burst leads into the gap
   a_r4_gap_after_tone: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(tone_on) && $past(tone_mode)) |-> !idle);

   // R7: mode off stops the burst
   a_r7_mode_off_stops: assert property (@(posedge clk) disable iff (!rst_n)
      !tone_mode |=> !tone_on);
endmodule

// File: rtl/dtmf_click.sv
module dtmf_click #(
   parameter int W        = 16,
   parameter int DIV      = 2983,
   parameter int LEN      = 125284,
   parameter int LEN_W    = 17
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic out
);
   logic             active;
   logic [LEN_W-1:0] lcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         lcnt   <= '0;
      end else if (start) begin
         active <= 1'b1;
         lcnt   <= '0;
      end else if (active) begin
         if (lcnt == LEN_W'(LEN - 1)) active <= 1'b0;
         else                         lcnt   <= lcnt + LEN_W'(1);
      end
   end

   dtmf_sqdiv #(.W(W)) u_kdiv (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (active),
      .div  (W'(DIV)),
      .sq   (out)
   );

   // R6: click begins high on a fresh burst
   a_r6_click_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !active) |=> out);
endmodule

// File: rtl/dtmf_tone_gen.sv
module dtmf_tone_gen
   import dtmf_pkg::*;
#(
   parameter int unsigned CLK_HZ    = 3579545,
   parameter int          TONE_CYC  = 332898,
   parameter int          GAP_CYC   = 332898,
   parameter int          CLICK_CYC = 125284,
   parameter int unsigned CLICK_HZ  = 1200,
   parameter int          DIV_W     = 16,
   parameter bit          CLICK_EN  = 1'b1,
   parameter int unsigned ROW_HZ [4] = '{699, 766, 848, 948},
   parameter int unsigned COL_HZ [3] = '{1216, 1332, 1472}
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tone_mode,
   input  logic       dig_valid,
   output logic       dig_ready,
   input  logic [3:0] dig_code,
   input  logic       single_en,
   input  logic       single_col,
   output logic       row_sq,
   output logic       col_sq,
   output logic       tone_on,
   output logic       click_out
);
   localparam int TMAX   = (TONE_CYC > GAP_CYC) ? TONE_CYC : GAP_CYC;
   localparam int CNT_W  = $clog2(TMAX + 1);
   localparam int LEN_W  = $clog2(CLICK_CYC + 1);
   localparam int unsigned KDIV = near_div(CLK_HZ, CLICK_HZ);

   logic [DIV_W-1:0] row_tab [4];
   logic [DIV_W-1:0] col_tab [3];

   for (genvar i = 0; i < 4; i++) begin : g_row
      localparam int unsigned D = near_div(CLK_HZ, ROW_HZ[i]);
      if (D < 2 || D >= (1 << DIV_W)) begin : g_bad
         $error("row divider out of range");
      end
      assign row_tab[i] = DIV_W'(D);
   end
   for (genvar j = 0; j < 3; j++) begin : g_col
      localparam int unsigned D = near_div(CLK_HZ, COL_HZ[j]);
      if (D < 2 || D >= (1 << DIV_W)) begin : g_bad
         $error("column divider out of range");
      end
      assign col_tab[j] = DIV_W'(D);
   end
   if (TONE_CYC < 1 || GAP_CYC < 1 || CLICK_CYC < 1) begin : g_bad_time
      $error("timing counts must be at least one");
   end

   logic       idle, start;
   logic [1:0] row_q, col_q;
   logic       sgl_q, sgl_col_q;

   assign dig_ready = tone_mode && idle;
   assign start     = dig_valid && dig_ready && code_ok(dig_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q     <= '0;
         col_q     <= '0;
         sgl_q     <= 1'b0;
         sgl_col_q <= 1'b0;
      end else if (start) begin
         row_q     <= row_of(dig_code);
         col_q     <= col_of(dig_code);
         sgl_q     <= single_en;
         sgl_col_q <= single_col;
      end
   end

   dtmf_seq #(.TONE_CYC(TONE_CYC), .GAP_CYC(GAP_CYC), .CNT_W(CNT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tone_mode(tone_mode),
      .start    (start),
      .tone_on  (tone_on),
      .idle     (idle)
   );

   logic row_en, col_en;
   assign row_en = tone_on && !(sgl_q && sgl_col_q);
   assign col_en = tone_on && !(sgl_q && !sgl_col_q);

   dtmf_sqdiv #(.W(DIV_W)) u_row (
      .clk(clk), .rst_n(rst_n), .en(row_en), .div(row_tab[row_q]), .sq(row_sq));
   dtmf_sqdiv #(.W(DIV_W)) u_col (
      .clk(clk), .rst_n(rst_n), .en(col_en), .div(col_tab[col_q]), .sq(col_sq));

   if (CLICK_EN) begin : g_click
      dtmf_click #(.W(DIV_W), .DIV(int'(KDIV)), .LEN(CLICK_CYC), .LEN_W(LEN_W)) u_click (
         .clk  (clk),
         .rst_n(rst_n),
         .start(start),
         .out  (click_out)
      );
   end else begin : g_noclick
      assign click_out = 1'b0;
   end

   // R5: muted group stays silent for the whole burst
   a_r5_single_row_only: assert property (@(posedge clk) disable iff (!rst_n)
      (sgl_q && !sgl_col_q) |-> !col_sq);
   a_r5_single_col_only: assert property (@(posedge clk) disable iff (!rst_n)
      (sgl_q && sgl_col_q) |-> !row_sq);

   // R7: nothing sounds while tone mode is off and the burst has ended
   a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !tone_mode |=> (!row_sq && !col_sq));

   // R8: out-of-range code keeps the block idle
   a_r8_bad_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (dig_valid && dig_ready && !code_ok(dig_code)) |=> !tone_on);
endmodule

// File: tb/dtmf_tone_gen_bench.sv
module dtmf_tone_gen_bench;
   localparam int TONE = 11000;
   localparam int GAP  = 1000;
   localparam int KLEN = 8000;
   localparam int unsigned FCLK = 3579545;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tone_mode = 1'b1;
   logic dig_valid = 1'b0;
   logic [3:0] dig_code = '0;
   logic single_en = 1'b0;
   logic single_col = 1'b0;
   logic dig_ready, row_sq, col_sq, tone_on, click_out;

   always #5 clk = ~clk;

   dtmf_tone_gen #(.TONE_CYC(TONE), .GAP_CYC(GAP), .CLICK_CYC(KLEN)) u_dtmf_tone_gen (
      .clk(clk), .rst_n(rst_n), .tone_mode(tone_mode), .dig_valid(dig_valid),
      .dig_ready(dig_ready), .dig_code(dig_code), .single_en(single_en),
      .single_col(single_col), .row_sq(row_sq), .col_sq(col_sq),
      .tone_on(tone_on), .click_out(click_out));

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   int rr_n, rr_a, rr_b, cr_n, cr_a, cr_b, kr_n, kr_a, kr_b;
   int on_cnt, rdy_at, leak, k_late;

   function automatic int exp_div(input int unsigned f);
      return int'((FCLK + f / 2) / f);
   endfunction

   function automatic int row_hz(input int r);
      case (r) 0: return 699; 1: return 766; 2: return 848; default: return 948; endcase
   endfunction

   function automatic int col_hz(input int c);
      case (c) 0: return 1216; 1: return 1332; default: return 1472; endcase
   endfunction

   function automatic int exp_row(input int code);
      if (code >= 1 && code <= 3) return 0;
      if (code >= 4 && code <= 6) return 1;
      if (code >= 7 && code <= 9) return 2;
      return 3;
   endfunction

   function automatic int exp_col(input int code);
      if (code == 1 || code == 4 || code == 7 || code == 10) return 0;
      if (code == 2 || code == 5 || code == 8 || code == 0)  return 1;
      return 2;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(input int code, input bit sgl, input bit scol);
      @(negedge clk);
      while (!dig_ready) @(negedge clk);
      dig_valid  = 1'b1;
      dig_code   = 4'(code);
      single_en  = sgl;
      single_col = scol;
      @(negedge clk);
      dig_valid  = 1'b0;
      single_en  = 1'b0;
   endtask

   task automatic observe(input int n);
      logic pr = 1'b0, pc = 1'b0, pk = 1'b0;
      rr_n = 0; cr_n = 0; kr_n = 0; rr_a = 0; rr_b = 0; cr_a = 0; cr_b = 0;
      kr_a = 0; kr_b = 0; on_cnt = 0; rdy_at = -1; leak = 0; k_late = 0;
      for (int i = 0; i < n; i++) begin
         if (row_sq && !pr) begin
            if (rr_n == 0) rr_a = i; else if (rr_n == 1) rr_b = i;
            rr_n++;
         end
         if (col_sq && !pc) begin
            if (cr_n == 0) cr_a = i; else if (cr_n == 1) cr_b = i;
            cr_n++;
         end
         if (click_out && !pk) begin
            if (kr_n == 0) kr_a = i; else if (kr_n == 1) kr_b = i;
            kr_n++;
         end
         if (tone_on) on_cnt++;
         if (!tone_on && (row_sq || col_sq)) leak++;
         if (i >= KLEN && click_out) k_late++;
         if (dig_ready && rdy_at < 0) rdy_at = i;
         pr = row_sq; pc = col_sq; pk = click_out;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dig_ready == 1'b1, "R9 ready", dig_ready, 1);
      chk({row_sq, col_sq, tone_on, click_out} == 4'b0, "R9 outputs low",
          {row_sq, col_sq, tone_on, click_out}, 0);
   endtask

   task automatic t_digit(input int code);
      int r = exp_row(code);
      int c = exp_col(code);
      send(code, 1'b0, 1'b0);
      observe(TONE + GAP + 2);
      chk(rr_n >= 2 && rr_b - rr_a == exp_div(row_hz(r)), "R1 row period",
          rr_b - rr_a, exp_div(row_hz(r)));
      chk(cr_n >= 2 && cr_b - cr_a == exp_div(col_hz(c)), "R2 col period",
          cr_b - cr_a, exp_div(col_hz(c)));
      chk(on_cnt == TONE && rr_a == 0 && cr_a == 0, "R3 burst length", on_cnt, TONE);
      chk(rdy_at == TONE + GAP, "R4 ready returns after gap", rdy_at, TONE + GAP);
      chk(leak == 0, "R3 waves only during burst", leak, 0);
   endtask

   task automatic t_click();
      send(1, 1'b0, 1'b0);
      observe(TONE + GAP + 2);
      chk(kr_a == 0 && kr_b - kr_a == exp_div(1200), "R6 click period",
          kr_b - kr_a, exp_div(1200));
      chk(kr_n == (KLEN + exp_div(1200) - 1) / exp_div(1200), "R6 click pulses",
          kr_n, (KLEN + exp_div(1200) - 1) / exp_div(1200));
      chk(k_late == 0, "R6 click ends", k_late, 0);
   endtask

   task automatic t_single(input int code, input bit scol);
      send(code, 1'b1, scol);
      observe(TONE + GAP + 2);
      if (!scol) begin
         chk(cr_n == 0, "R5 column muted", cr_n, 0);
         chk(rr_n >= 2 && rr_b - rr_a == exp_div(row_hz(exp_row(code))), "R5 row sounds",
             rr_b - rr_a, exp_div(row_hz(exp_row(code))));
      end else begin
         chk(rr_n == 0, "R5 row muted", rr_n, 0);
         chk(cr_n >= 2 && cr_b - cr_a == exp_div(col_hz(exp_col(code))), "R5 column sounds",
             cr_b - cr_a, exp_div(col_hz(exp_col(code))));
      end
   endtask

   task automatic t_bad_code();
      send(13, 1'b0, 1'b0);
      observe(200);
      chk(on_cnt == 0 && rr_n == 0 && cr_n == 0, "R8 no tone", on_cnt, 0);
      chk(kr_n == 0, "R8 no click", kr_n, 0);
      chk(rdy_at == 0, "R8 ready stays high", rdy_at, 0);
   endtask

   task automatic t_mode_off();
      int seen = 0;
      send(2, 1'b0, 1'b0);
      repeat (100) @(negedge clk);
      tone_mode = 1'b0;
      @(negedge clk);
      chk({tone_on, row_sq, col_sq, dig_ready} == 4'b0, "R7 burst stopped",
          {tone_on, row_sq, col_sq, dig_ready}, 0);
      dig_valid = 1'b1;
      dig_code  = 4'd3;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (tone_on || row_sq || col_sq || dig_ready) seen++;
      end
      dig_valid = 1'b0;
      chk(seen == 0, "R7 refused while off", seen, 0);
      tone_mode = 1'b1;
      @(negedge clk);
      chk(dig_ready == 1'b1 && tone_on == 1'b0, "R7 nothing queued", tone_on, 0);
   endtask

   initial begin
      t_reset();
      t_click();
      t_digit(5);
      t_digit(9);
      t_digit(0);
      t_digit(10);
      t_digit(11);
      t_single(8, 1'b0);
      t_single(6, 1'b1);
      t_bad_code();
      t_mode_off();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule